// File: doc/BRIEF.md
# Channel-Status Block Framer

This block sits after a digital audio receiver's subframe decoder. The decoder reports three things: the start of each frame, whether that frame opened with the block-start (Z) preamble, and, for each subframe, its channel-status (C) and user-data (U) bits with a left/right tag. From these the block keeps a frame index inside the 192-frame channel-status block. It raises a block marker a fixed number of frames after the Z preamble and holds it for a fixed run of frames.

In parallel, the block turns the captured C and U bits into two serial streams that follow an external left/right word clock. That clock is asynchronous to the master clock. It is synchronised and edge-detected rather than used as a clock. On each of its edges the block drives out the bit of the subframe that the new word-clock level selects. Downstream logic therefore gets one C bit and one U bit per subframe.

Top module: `cs_block_framer`

## Requirements
- R1: The marker `blk_mark` goes high one master clock after the strobe of the frame whose index is 2, where the Z frame has index 0.
- R2: The marker stays high for 16 frames and goes low one clock after the strobe of the frame with index 18. It then stays low for the rest of the block.
- R3: Without a new Z preamble, the frame index wraps from 191 back to 0, so the marker recurs at index 2 of each following 192-frame block.
- R4: A Z preamble arriving at any index restarts the index at 0. An active marker drops at once and rises again two frames later.
- R5: Reset drives `blk_mark`, `c_out` and `u_out` low. No marker appears until the first frame flagged with `z_pre` has been seen.
- R6: `blk_mark` changes only in the master-clock cycle that follows a `frame_stb` pulse. Between frame strobes it holds its value.
- R7: Within four master clocks of a rising `wclk` edge, `c_out` shows the C bit last captured for the left subframe (`sub_right`=0). After a falling edge it shows the C bit last captured for the right subframe (`sub_right`=1).
- R8: `u_out` follows the same edge timing and left/right selection as `c_out`, carrying the captured U bits.
- R9: Capturing new C/U bits with `sub_stb` does not change `c_out` or `u_out` until the next `wclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse at the start of each frame |
| z_pre | input | 1 | Qualifies `frame_stb`: this frame began with a Z preamble |
| sub_stb | input | 1 | One-cycle pulse presenting one subframe's C and U bits |
| sub_right | input | 1 | Subframe tag with `sub_stb`: 0 left, 1 right |
| c_bit | input | 1 | Channel-status bit of the presented subframe |
| u_bit | input | 1 | User-data bit of the presented subframe |
| wclk | input | 1 | Asynchronous left/right word clock |
| blk_mark | output | 1 | Channel-status block marker |
| c_out | output | 1 | Serial channel-status output |
| u_out | output | 1 | Serial user-data output |

## Verification
The frame-index path and the word-clock path are independent, and both can update their registers on the same master-clock edge. In that case `blk_mark` moves together with `c_out` and `u_out`. A directed case toggles `wclk` exactly two negative edges before a frame strobe, so that the detected word-clock edge and the strobe land on one clock. The random phase also mixes frame strobes, subframe captures and word-clock toggles freely. In each case the bench judges the marker against its frame-index model and the serial outputs against its captured left/right bits, and neither result may disturb the other.

// File: rtl/cs_block_framer.sv
module cs_block_framer #(
  parameter int FRAMES     = 192,
  parameter int MARK_DELAY = 2,
  parameter int MARK_LEN   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic z_pre,
  input  logic sub_stb,
  input  logic sub_right,
  input  logic c_bit,
  input  logic u_bit,
  input  logic wclk,
  output logic blk_mark,
  output logic c_out,
  output logic u_out
);
  localparam int CW = $clog2(FRAMES);
  localparam logic [CW-1:0] LAST   = CW'(FRAMES - 1);
  localparam logic [CW-1:0] MSTART = CW'(MARK_DELAY);
  localparam logic [CW-1:0] MEND   = CW'(MARK_DELAY + MARK_LEN);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic          seen;
  logic          seen_nx;
  logic [2:0]    ws;
  logic          wedge;
  logic          lc, lu, rc, ru;

  assign cnt_nx  = (z_pre || cnt == LAST) ? '0 : cnt + 1'b1;
  assign seen_nx = seen | z_pre;
  assign wedge   = ws[2] ^ ws[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      seen     <= 1'b0;
      blk_mark <= 1'b0;
    end else if (frame_stb) begin
      cnt      <= cnt_nx;
      seen     <= seen_nx;
      blk_mark <= seen_nx && cnt_nx >= MSTART && cnt_nx < MEND;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lc, lu, rc, ru} <= '0;
    end else if (sub_stb) begin
      if (sub_right) {rc, ru} <= {c_bit, u_bit};
      else           {lc, lu} <= {c_bit, u_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws    <= '0;
      c_out <= 1'b0;
      u_out <= 1'b0;
    end else begin
      ws <= {ws[1:0], wclk};
      if (wedge) begin
        c_out <= ws[1] ? lc : rc;
        u_out <= ws[1] ? lu : ru;
      end
    end
  end

  AST_MARK_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_mark) |-> $past(frame_stb)); // R6
  AST_Z_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && z_pre |=> cnt == '0); // R4
  AST_NO_MARK_AT_Z: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && z_pre |=> !blk_mark); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R3
  AST_MARK_NEEDS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !blk_mark); // R5
  AST_C_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(c_out) |-> $past(wedge)); // R7
  AST_U_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(u_out) |-> $past(wedge)); // R8
endmodule

// File: tb/cs_block_framer_test.sv
`timescale 1ns/1ps
module cs_block_framer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_stb = 0, z_pre = 0, sub_stb = 0, sub_right = 0, c_bit = 0, u_bit = 0, wclk = 0;
  logic blk_mark, c_out, u_out;
  int checks = 0, errors = 0;

  bit m_seen = 0;
  int m_idx  = 0;
  bit ml_c = 0, ml_u = 0, mr_c = 0, mr_u = 0;
  bit mc = 0, mu = 0;

  always #2.5 clk = ~clk;

  cs_block_framer uut (.clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .z_pre(z_pre),
    .sub_stb(sub_stb), .sub_right(sub_right), .c_bit(c_bit), .u_bit(u_bit), .wclk(wclk),
    .blk_mark(blk_mark), .c_out(c_out), .u_out(u_out));

  function automatic bit exp_mark(bit seen, int idx);
    return seen && idx >= 2 && idx < 18;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic frame(bit z, string req);
    @(negedge clk); frame_stb = 1; z_pre = z;
    @(negedge clk); frame_stb = 0; z_pre = 0;
    if (z) begin m_idx = 0; m_seen = 1; end
    else m_idx = (m_idx == 191) ? 0 : m_idx + 1;
    check(req, blk_mark, exp_mark(m_seen, m_idx));
    repeat (2) @(negedge clk);
    check("R6 hold", blk_mark, exp_mark(m_seen, m_idx));
  endtask

  task automatic sub(bit r, bit c, bit u);
    @(negedge clk); sub_stb = 1; sub_right = r; c_bit = c; u_bit = u;
    @(negedge clk); sub_stb = 0;
    if (r) begin mr_c = c; mr_u = u; end else begin ml_c = c; ml_u = u; end
  endtask

  task automatic toggle_w();
    @(negedge clk); wclk = ~wclk;
    mc = wclk ? ml_c : mr_c;
    mu = wclk ? ml_u : mr_u;
    repeat (4) @(negedge clk);
    check("R7 c_out", c_out, mc);
    check("R8 u_out", u_out, mu);
  endtask

  initial begin
    #(2_000_000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    repeat (3) @(negedge clk);
    check("R5 reset mark", blk_mark, 1'b0);
    check("R5 reset c", c_out, 1'b0);
    check("R5 reset u", u_out, 1'b0);
    rst_n = 1;
    for (int i = 0; i < 6; i++) frame(0, "R5 no mark before Z");
    frame(1, "R1 Z frame");
    for (int i = 1; i < 20; i++) frame(0, "R1 R2 marker window");
    for (int i = 20; i < 200; i++) frame(0, "R3 wrap");
    frame(1, "R4 Z");
    for (int i = 1; i < 10; i++) frame(0, "R4 pre");
    frame(1, "R4 early Z drops marker");
    frame(0, "R4 re-timed");
    frame(0, "R4 re-timed rise");
    frame(0, "R4 high");

    sub(0, 1, 0); sub(1, 0, 1);
    toggle_w();
    toggle_w();
    sub(0, 0, 1); sub(1, 1, 0);
    repeat (6) @(negedge clk);
    check("R9 c hold", c_out, mc);
    check("R9 u hold", u_out, mu);
    toggle_w();
    toggle_w();

    @(negedge clk); wclk = ~wclk;
    mc = wclk ? ml_c : mr_c; mu = wclk ? ml_u : mr_u;
    @(negedge clk);
    frame(0, "R2 coincident frame");
    check("R7 coincident c", c_out, mc);
    check("R8 coincident u", u_out, mu);

    for (int i = 0; i < 1500; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) frame($urandom_range(0, 39) == 0, "R3 R4 random frame");
      else if (op < 7) sub(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      else toggle_w();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule